// File: doc/BRIEF.md
# Table-Steered Stream Process Node

This block wraps one process of a streaming process network in hardware. Each firing of the node does three things in a fixed order. It takes one operand from one of two input streams, combines that operand with the current loop indices, and hands the result to one of two output streams. The node then moves to the next firing.

The iterations follow a triangular nested loop. The outer index `j` counts from 1 to `N`, and the inner index `i` counts from `j` to `N`. A small control table picks the ports for each iteration. It is not stored; it is computed from `(j, i)`.

Every stream uses a valid/ready handshake, and this handshake is the only synchronisation. An empty input holds the node in its read step, and a busy output holds it in its write step. No scheduler outside the node is needed, and no data is lost.

Top module: `stream_node`

## Requirements
- R1: A synchronous active-high reset returns the node to iteration (j=1, i=1) in its read step. After reset, `done` is 0, both outputs are invalid, and only `in_b_ready` is high.
- R2: In its read step the node raises the ready of exactly one input. It uses input B when i equals j, and input A otherwise.
- R3: While the selected input is not valid, the node waits in its read step. It produces no output and never raises the ready of the other input, so data offered there is not consumed.
- R4: The result of an iteration is the consumed operand plus i plus j, modulo 2^W.
- R5: The result is offered on output B when i equals N, and on output A otherwise. Only one output is valid at a time.
- R6: While an offered result is not accepted, the output stays valid and its data stays unchanged.
- R7: Results appear in loop order (j ascending, then i ascending from j to N), one per iteration, N(N+1)/2 in total.
- R8: Once the result of iteration (N, N) is accepted, `done` rises and stays high until reset. After that, neither input is ready and neither output is valid.
- R9: Firings do not overlap. Between a read handshake and the acceptance of its result, neither input is ready.
- R10: The behaviour above holds for N = 1, N = 5 and N = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a_valid | input | 1 | Input A carries data |
| in_a_data | input | W | Input A operand |
| in_a_ready | output | 1 | Node takes input A this cycle if valid |
| in_b_valid | input | 1 | Input B carries data |
| in_b_data | input | W | Input B operand |
| in_b_ready | output | 1 | Node takes input B this cycle if valid |
| out_a_valid | output | 1 | Result offered on output A |
| out_a_data | output | W | Output A result |
| out_a_ready | input | 1 | Consumer of output A accepts |
| out_b_valid | output | 1 | Result offered on output B |
| out_b_data | output | W | Output B result |
| out_b_ready | input | 1 | Consumer of output B accepts |
| done | output | 1 | Final iteration completed |

## Verification
The hardest case to bring about is a stall on the port that the table did not pick. To reach it, the bench keeps the selected input empty for several cycles while the other input offers valid data. It then confirms that nothing is consumed and that no result appears.

Output back-pressure is held for a different number of cycles on each iteration, including the first one. This exposes any result that changes or is lost while the node waits.

Two further instances, one with N=1 and one with N=8, run with constant operands and sinks that are always ready. They check the triangular order, the port steering and the end of the domain at the smallest size and at a larger one.

// File: rtl/stream_node.sv
module stream_node #(
  parameter int N = 5,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_a_valid,
  input  logic [W-1:0] in_a_data,
  output logic         in_a_ready,
  input  logic         in_b_valid,
  input  logic [W-1:0] in_b_data,
  output logic         in_b_ready,
  output logic         out_a_valid,
  output logic [W-1:0] out_a_data,
  input  logic         out_a_ready,
  output logic         out_b_valid,
  output logic [W-1:0] out_b_data,
  input  logic         out_b_ready,
  output logic         done
);
  localparam int CW = $clog2(N + 2);
  localparam logic [CW-1:0] LAST = CW'(N);

  typedef enum logic [1:0] {S_RD, S_EX, S_WR, S_END} st_t;

  st_t           st;
  logic [CW-1:0] jj, ii;
  logic [W-1:0]  opnd, res;

  wire take_b  = (ii == jj);
  wire put_b   = (ii == LAST);
  wire at_last = (jj == LAST) && (ii == LAST);

  assign in_a_ready  = (st == S_RD) && !take_b;
  assign in_b_ready  = (st == S_RD) && take_b;
  assign out_a_valid = (st == S_WR) && !put_b;
  assign out_b_valid = (st == S_WR) && put_b;
  assign out_a_data  = res;
  assign out_b_data  = res;
  assign done        = (st == S_END);

  wire rd_fire = (in_a_ready && in_a_valid) || (in_b_ready && in_b_valid);
  wire wr_fire = (out_a_valid && out_a_ready) || (out_b_valid && out_b_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_RD;
      jj   <= CW'(1);
      ii   <= CW'(1);
      opnd <= '0;
      res  <= '0;
    end else begin
      case (st)
        S_RD: if (rd_fire) begin
          opnd <= take_b ? in_b_data : in_a_data;
          st   <= S_EX;
        end
        S_EX: begin
          res <= opnd + W'(ii) + W'(jj);
          st  <= S_WR;
        end
        S_WR: if (wr_fire) begin
          if (at_last) st <= S_END;
          else begin
            st <= S_RD;
            if (put_b) begin
              jj <= jj + CW'(1);
              ii <= jj + CW'(1);
            end else begin
              ii <= ii + CW'(1);
            end
          end
        end
        default: st <= S_END;
      endcase
    end
  end

  assert_domain_R7: assert property (@(posedge clk) disable iff (rst)
    (jj >= CW'(1)) && (ii >= jj) && (ii <= LAST));
  assert_hold_a_R6: assert property (@(posedge clk) disable iff (rst)
    (out_a_valid && !out_a_ready) |=> (out_a_valid && $stable(out_a_data)));
  assert_hold_b_R6: assert property (@(posedge clk) disable iff (rst)
    (out_b_valid && !out_b_ready) |=> (out_b_valid && $stable(out_b_data)));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    (out_a_valid || out_b_valid) |-> !(in_a_ready || in_b_ready));
  assert_one_out_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_a_valid, out_b_valid}));
endmodule

// File: tb/tb_stream_node.sv
module tb_stream_node;
  localparam int NM = 5;
  localparam int W  = 16;
  localparam logic [W-1:0] FA = 16'h0200;
  localparam logic [W-1:0] FB = 16'h0700;

  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic a_v = 0, b_v = 0, oa_r = 0, ob_r = 0;
  logic [W-1:0] a_d = '0, b_d = '0;
  logic a_r, b_r, oa_v, ob_v, dn;
  logic [W-1:0] oa_d, ob_d;

  stream_node #(.N(NM), .W(W)) dut (
    .clk(clk), .rst(rst),
    .in_a_valid(a_v), .in_a_data(a_d), .in_a_ready(a_r),
    .in_b_valid(b_v), .in_b_data(b_d), .in_b_ready(b_r),
    .out_a_valid(oa_v), .out_a_data(oa_d), .out_a_ready(oa_r),
    .out_b_valid(ob_v), .out_b_data(ob_d), .out_b_ready(ob_r),
    .done(dn));

  logic [1:0] f_av, f_bv, f_ar, f_br, f_dn;
  logic [W-1:0] f_ad [2];
  logic [W-1:0] f_bd [2];

  stream_node #(.N(1), .W(W)) dut_n1 (
    .clk(clk), .rst(rst),
    .in_a_valid(1'b1), .in_a_data(FA), .in_a_ready(f_ar[0]),
    .in_b_valid(1'b1), .in_b_data(FB), .in_b_ready(f_br[0]),
    .out_a_valid(f_av[0]), .out_a_data(f_ad[0]), .out_a_ready(1'b1),
    .out_b_valid(f_bv[0]), .out_b_data(f_bd[0]), .out_b_ready(1'b1),
    .done(f_dn[0]));

  stream_node #(.N(8), .W(W)) dut_n8 (
    .clk(clk), .rst(rst),
    .in_a_valid(1'b1), .in_a_data(FA), .in_a_ready(f_ar[1]),
    .in_b_valid(1'b1), .in_b_data(FB), .in_b_ready(f_br[1]),
    .out_a_valid(f_av[1]), .out_a_data(f_ad[1]), .out_a_ready(1'b1),
    .out_b_valid(f_bv[1]), .out_b_data(f_bd[1]), .out_b_ready(1'b1),
    .done(f_dn[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(dn == 0, "R1 done in reset", int'(dn), 0);
    rst = 0;
    @(negedge clk);
    chk(b_r == 1 && a_r == 0, "R1 ready after reset", {a_r, b_r}, 1);
    chk(oa_v == 0 && ob_v == 0, "R1 outputs idle", {oa_v, ob_v}, 0);
    chk(dn == 0, "R1 done low", int'(dn), 0);
  endtask

  task automatic do_iter(input int j, input int i, input int gap, input int stall);
    bit sel_b = (i == j);
    logic [W-1:0] d = W'(16'h1000 + 16 * j + i);
    logic [W-1:0] expv = d + W'(i) + W'(j);
    bit got = 0;
    chk(b_r == sel_b && a_r == !sel_b, "R2 input select", {a_r, b_r}, {!sel_b, sel_b});
    if (gap > 0) begin
      if (sel_b) begin a_v = 1; a_d = 16'hDEAD; end
      else       begin b_v = 1; b_d = 16'hBEEF; end
      repeat (gap) @(negedge clk);
      chk(!oa_v && !ob_v, "R3 no output while blocked", {oa_v, ob_v}, 0);
      chk(sel_b ? !a_r : !b_r, "R3 other input not consumed", {a_r, b_r}, sel_b ? 1 : 2);
      a_v = 0; b_v = 0;
    end
    if (sel_b) begin b_v = 1; b_d = d; end
    else       begin a_v = 1; a_d = d; end
    @(negedge clk);
    a_v = 0; b_v = 0;
    for (int k = 0; k < 10; k++) begin
      if (oa_v || ob_v) begin got = 1; break; end
      chk(!a_r && !b_r, "R9 no read while busy", {a_r, b_r}, 0);
      @(negedge clk);
    end
    chk(got, "R7 result appears", int'(got), 1);
    chk(ob_v == (i == NM) && oa_v == (i != NM), "R5 output select", {oa_v, ob_v}, (i == NM) ? 1 : 2);
    chk((i == NM ? ob_d : oa_d) == expv, "R4 result value", int'(i == NM ? ob_d : oa_d), int'(expv));
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk((i == NM ? ob_v : oa_v) && (i == NM ? ob_d : oa_d) == expv,
          "R6 held under stall", int'(i == NM ? ob_d : oa_d), int'(expv));
      chk(!a_r && !b_r, "R9 no read during stall", {a_r, b_r}, 0);
    end
    oa_r = 1; ob_r = 1;
    @(negedge clk);
    oa_r = 0; ob_r = 0;
  endtask

  task automatic t_main_run();
    for (int j = 1; j <= NM; j++)
      for (int i = j; i <= NM; i++)
        do_iter(j, i, (j == 1 && i == 1) ? 4 : (i % 3), (j == 1 && i == 1) ? 4 : ((i + j) % 3));
    chk(dn == 1, "R8 done after last", int'(dn), 1);
    a_v = 1; b_v = 1; oa_r = 1; ob_r = 1;
    repeat (4) @(negedge clk);
    chk(dn == 1 && !a_r && !b_r, "R8 done sticky, no reads", {dn, a_r, b_r}, 4);
    chk(!oa_v && !ob_v, "R8 no output after done", {oa_v, ob_v}, 0);
    a_v = 0; b_v = 0; oa_r = 0; ob_r = 0;
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dn == 0 && b_r == 1 && a_r == 0, "R1 reset after done", {dn, a_r, b_r}, 1);
  endtask

  task automatic run_free(input int k, input int n);
    int seen = 0;
    for (int j = 1; j <= n; j++)
      for (int i = j; i <= n; i++) begin
        bit got = 0;
        logic [W-1:0] expv = ((i == j) ? FB : FA) + W'(i) + W'(j);
        for (int c = 0; c < 12; c++) begin
          @(negedge clk);
          if (f_av[k] || f_bv[k]) begin got = 1; break; end
        end
        chk(got, "R10 R7 free-run result", int'(got), 1);
        chk(f_bv[k] == (i == n) && f_av[k] == (i != n), "R10 R5 free-run port", {f_av[k], f_bv[k]}, (i == n) ? 1 : 2);
        chk((i == n ? f_bd[k] : f_ad[k]) == expv, "R10 R4 free-run value", int'(i == n ? f_bd[k] : f_ad[k]), int'(expv));
        seen++;
      end
    repeat (3) @(negedge clk);
    chk(f_dn[k] == 1 && !f_av[k] && !f_bv[k], "R10 R8 free-run done", {f_dn[k], f_av[k], f_bv[k]}, 4);
    chk(seen == n * (n + 1) / 2, "R7 iteration count", seen, n * (n + 1) / 2);
  endtask

  initial begin
    fork
      begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
          fails++;
          checks++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
          $finish;
        end
      end
    join_none
    t_reset();
    fork
      run_free(0, 1);
      run_free(1, 8);
      t_main_run();
    join
    t_rereset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule